// File: doc/BRIEF.md
# Spatial Random-Subset Compressive Encoder

This block compresses a 16-channel recording array across space rather than over time. Once per frame it asks the channels for fresh held samples and captures all sixteen 8-bit values at the same instant. Those values then stay frozen while the block produces a short burst of measurements. Each measurement is the sum of only those channels whose pseudo-random selection bit is set for that measurement.

The selection bits come from two free-running maximal-length shift registers of different lengths. Each channel's bit is the XOR of one stage of each register. Both registers step once for every measurement that is issued, so a receiver that knows the seeds can rebuild the selection pattern.

All timing is taken from one master clock. A measurement slot is 20 clocks and a frame is 5 slots, or 100 clocks. At a 400 kHz clock this gives 20 kS/s of measurements and 4 kS/s per channel. The number of measurements per frame, M, is set at run time. The compression ratio is 16/M, and the highest ratio is 16x, at M = 1. The sum is formed at 12-bit precision, and the upper 10 bits are reported.

Top module: `cs_spatial_encoder`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `meas`, `meas_valid`, `frame_start` and `sample_req` are all zero. Reset loads the 7-bit register A with 7'h55 and the 9-bit register B with 9'h1A5.
- R2: While `enable` is high, the block repeats 100-clock frames. `sample_req` is a one-cycle pulse in the second cycle of each frame. When `enable` is low, the sequencer clears and no pulse appears on any output. The next frame starts on the first cycle in which `enable` is high again.
- R3: The channel samples are captured at the clock edge that ends the cycle after the `sample_req` cycle. Later changes on `samples` have no effect on any measurement of that frame.
- R4: Channel i occupies `samples[8i+7:8i]`. A measurement equals S >> 2, where S is the 12-bit sum of the captured samples of every channel whose selection bit is 1. Channels whose bit is 0 add nothing. The largest possible result, 1020, is reported without wrap.
- R5: Register A steps as A <= {A[5:0], A[6]^A[5]}. Register B steps as B <= {B[7:0], B[8]^B[4]}. The selection bit of channel i is A[i mod 7] XOR B[(i+3) mod 9], taken from the register values held during that measurement's slot.
- R6: Both registers step exactly once for each measurement issued. They do not step for unused slots or while `enable` is low.
- R7: `meas_valid` is a one-cycle strobe. Measurement k of a frame (k = 0 first) is valid 19 + 20k cycles after the `sample_req` cycle. `frame_start` is high together with measurement 0 only.
- R8: The number of measurements per frame is `m_cfg` clamped to the range 1 to 5. A value of 0 gives 1, and any value above 5 gives 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run control; low clears the sequencer |
| m_cfg | input | 5 | Requested measurements per frame (clamped 1..5) |
| samples | input | 128 | Sixteen 8-bit channel samples, channel i at bits 8i+7:8i |
| meas | output | 10 | Compressed measurement (sum bits 11:2) |
| meas_valid | output | 1 | One-cycle strobe marking a new measurement |
| frame_start | output | 1 | Marks the first measurement of a frame |
| sample_req | output | 1 | One-cycle request for fresh channel samples |

## Verification
Every result is due at a fixed number of cycles after the `sample_req` cycle. The samples must be held through offset 1. Measurement k is due at offset 19 + 20k, and the next request comes at offset 100. The bench locks onto each `sample_req` at a falling edge and steps falling edges from there. It checks the value, `frame_start` and the strobe at exactly those offsets, and counts any pulse seen at any other offset as a stray. The bench overwrites the samples at offset 2. It computes the expected sums from the values it first drove, using its own copy of both shift registers, which steps once per expected measurement.

// File: rtl/cs_enc_pkg.sv
package cs_enc_pkg;

  // Per-slot control strobes issued by the sequencer
  typedef struct packed {
    logic latch;   // capture channel samples (slot 0 only)
    logic clear;   // clear accumulator and capture selection mask
    logic add;     // accumulate one channel this cycle
    logic last;    // final cycle of the slot
  } seq_strb_t;

  // Output width: input width plus half the channel-count log
  function automatic int meas_width(input int sw, input int nch);
    return sw + ($clog2(nch) / 2);
  endfunction

endpackage

// File: rtl/cs_frame_seq.sv
module cs_frame_seq
  import cs_enc_pkg::*;
#(
  parameter int NCH         = 16,
  parameter int SLOT_CLKS   = 20,
  parameter int FRAME_SLOTS = 5,
  parameter int LATCH_CYC   = 2,
  localparam int CW  = $clog2(SLOT_CLKS),
  localparam int SLW = $clog2(FRAME_SLOTS),
  localparam int IW  = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  output logic [SLW-1:0] slot,
  output seq_strb_t      strb,
  output logic [IW-1:0]  sum_idx,
  output logic           sample_req
);

  localparam int SUM_START = LATCH_CYC + 1;
  localparam int SUM_END   = SUM_START + NCH - 1;

  logic [CW-1:0] cyc;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cyc  <= '0;
      slot <= '0;
    end else if (cyc == CW'(SLOT_CLKS - 1)) begin
      cyc  <= '0;
      slot <= (slot == SLW'(FRAME_SLOTS - 1)) ? '0 : slot + 1'b1;
    end else begin
      cyc <= cyc + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sample_req <= 1'b0;
    else     sample_req <= en && (cyc == '0) && (slot == '0);
  end

  always_comb begin
    strb.latch = en && (slot == '0) && (cyc == CW'(LATCH_CYC));
    strb.clear = en && (cyc == CW'(LATCH_CYC));
    strb.add   = en && (cyc >= CW'(SUM_START)) && (cyc <= CW'(SUM_END));
    strb.last  = en && (cyc == CW'(SLOT_CLKS - 1));
    sum_idx    = IW'(cyc - CW'(SUM_START));
  end

endmodule

// File: rtl/cs_prbs_mask.sv
module cs_prbs_mask #(
  parameter int NCH    = 16,
  parameter int LA     = 7,
  parameter int FA     = 6,
  parameter int LB     = 9,
  parameter int FB     = 5,
  parameter int KOFF   = 3,
  parameter logic [LA-1:0] SEED_A = 7'h55,
  parameter logic [LB-1:0] SEED_B = 9'h1A5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           adv,
  input  logic           cap,
  output logic [NCH-1:0] mask
);

  logic [LA-1:0]  reg_a;
  logic [LB-1:0]  reg_b;
  logic [NCH-1:0] sel_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_a <= SEED_A;
      reg_b <= SEED_B;
    end else if (adv) begin
      reg_a <= {reg_a[LA-2:0], reg_a[LA-1] ^ reg_a[FA-1]};
      reg_b <= {reg_b[LB-2:0], reg_b[LB-1] ^ reg_b[FB-1]};
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_sel
    assign sel_now[i] = reg_a[i % LA] ^ reg_b[(i + KOFF) % LB];
  end

  always_ff @(posedge clk) begin
    if (rst)      mask <= '0;
    else if (cap) mask <= sel_now;
  end

endmodule

// File: rtl/cs_serial_sum.sv
module cs_serial_sum #(
  parameter int NCH = 16,
  parameter int SW  = 8,
  localparam int IW = $clog2(NCH),
  localparam int AW = SW + $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              latch,
  input  logic              clear,
  input  logic              add,
  input  logic [IW-1:0]     idx,
  input  logic [NCH-1:0]    mask,
  input  logic [NCH*SW-1:0] samples,
  output logic [AW-1:0]     acc
);

  logic [SW-1:0] hold [NCH];
  logic [SW-1:0] term;

  always_ff @(posedge clk) begin
    if (latch) begin
      for (int i = 0; i < NCH; i++) hold[i] <= samples[i*SW +: SW];
    end
  end

  assign term = mask[idx] ? hold[idx] : '0;

  always_ff @(posedge clk) begin
    if (rst || clear) acc <= '0;
    else if (add)     acc <= acc + AW'(term);
  end

endmodule

// File: rtl/cs_spatial_encoder.sv
module cs_spatial_encoder
  import cs_enc_pkg::*;
#(
  parameter int NCH         = 16,
  parameter int SW          = 8,
  parameter int SLOT_CLKS   = 20,
  parameter int FRAME_SLOTS = 5,
  parameter int MCW         = 5,
  localparam int OW  = meas_width(SW, NCH),
  localparam int AW  = SW + $clog2(NCH),
  localparam int SLW = $clog2(FRAME_SLOTS),
  localparam int IW  = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [MCW-1:0]    m_cfg,
  input  logic [NCH*SW-1:0] samples,
  output logic [OW-1:0]     meas,
  output logic              meas_valid,
  output logic              frame_start,
  output logic              sample_req
);

  seq_strb_t      strb;
  logic [SLW-1:0] slot;
  logic [IW-1:0]  sum_idx;
  logic [NCH-1:0] mask;
  logic [AW-1:0]  acc;
  logic [MCW-1:0] m_eff;
  logic           slot_act;
  logic           issue;

  always_comb begin
    if (m_cfg == '0)                     m_eff = MCW'(1);
    else if (m_cfg > MCW'(FRAME_SLOTS))  m_eff = MCW'(FRAME_SLOTS);
    else                                 m_eff = m_cfg;
  end

  assign slot_act = MCW'(slot) < m_eff;
  assign issue    = strb.last && slot_act;

  cs_frame_seq #(
    .NCH(NCH), .SLOT_CLKS(SLOT_CLKS), .FRAME_SLOTS(FRAME_SLOTS), .LATCH_CYC(2)
  ) u_seq (
    .clk(clk), .rst(rst), .en(enable), .slot(slot), .strb(strb),
    .sum_idx(sum_idx), .sample_req(sample_req)
  );

  cs_prbs_mask #(.NCH(NCH)) u_prbs (
    .clk(clk), .rst(rst), .adv(issue), .cap(strb.clear), .mask(mask)
  );

  cs_serial_sum #(.NCH(NCH), .SW(SW)) u_sum (
    .clk(clk), .rst(rst), .latch(strb.latch), .clear(strb.clear),
    .add(strb.add), .idx(sum_idx), .mask(mask), .samples(samples), .acc(acc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      meas        <= '0;
      meas_valid  <= 1'b0;
      frame_start <= 1'b0;
    end else begin
      meas_valid  <= 1'b0;
      frame_start <= 1'b0;
      if (issue) begin
        meas        <= acc[AW-1 -: OW];
        meas_valid  <= 1'b1;
        frame_start <= (slot == '0);
      end
    end
  end

endmodule

// File: rtl/cs_encoder_chk.sv
module cs_encoder_chk #(
  parameter int OW = 10,
  parameter int MAXV = 1020
) (
  input logic          clk,
  input logic          rst,
  input logic          enable,
  input logic [OW-1:0] meas,
  input logic          meas_valid,
  input logic          frame_start,
  input logic          sample_req
);

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    meas_valid |=> !meas_valid);                                     // R7
  AST_FS_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> meas_valid);                                     // R7
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    sample_req |=> !sample_req);                                     // R2
  AST_REQ_NOT_WITH_MEAS: assert property (@(posedge clk) disable iff (rst)
    sample_req |-> !meas_valid);                                     // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !$past(enable) |-> (!meas_valid && !sample_req));                // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    meas_valid |-> (meas <= OW'(MAXV)));                             // R4
  AST_HOLD_MEAS: assert property (@(posedge clk) disable iff (rst)
    !meas_valid && !$past(rst) |-> $stable(meas));                   // R4

endmodule

bind cs_spatial_encoder cs_encoder_chk #(.OW(OW)) u_chk (
  .clk(clk), .rst(rst), .enable(enable), .meas(meas),
  .meas_valid(meas_valid), .frame_start(frame_start), .sample_req(sample_req)
);

// File: tb/cs_spatial_encoder_test.sv
module cs_spatial_encoder_test;
  localparam int NCH = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         enable = 1'b0;
  logic [4:0]   m_cfg = 5'd4;
  logic [127:0] samples = '0;
  logic [9:0]   meas;
  logic         meas_valid, frame_start, sample_req;

  int checks = 0;
  int fails = 0;
  logic [6:0] ma;
  logic [8:0] mb;
  logic [7:0] vals [NCH];

  cs_spatial_encoder uut (
    .clk(clk), .rst(rst), .enable(enable), .m_cfg(m_cfg), .samples(samples),
    .meas(meas), .meas_valid(meas_valid), .frame_start(frame_start),
    .sample_req(sample_req)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expect_meas(input logic [6:0] a, input logic [8:0] b);
    int s = 0;
    for (int i = 0; i < NCH; i++)
      if (a[i % 7] ^ b[(i + 3) % 9]) s += vals[i];
    return s >> 2;
  endfunction

  task automatic model_step();
    ma = {ma[5:0], ma[6] ^ ma[5]};
    mb = {mb[7:0], mb[8] ^ mb[4]};
  endtask

  // Runs one frame: waits for the request, drives vals, scrambles after capture
  task automatic do_frame(input int n_exp);
    int w = 0;
    int stray = 0;
    @(negedge clk);
    while (!sample_req && w < 300) begin @(negedge clk); w++; end
    chk(sample_req, "R2 sample_req seen", sample_req, 1);
    for (int i = 0; i < NCH; i++) samples[i*8 +: 8] = vals[i];
    for (int off = 1; off < 100; off++) begin
      @(negedge clk);
      if (off == 2) samples = samples ^ {16{8'h5A}};  // R3: ignored after capture
      if (off >= 19 && (off - 19) % 20 == 0 && (off - 19) / 20 < n_exp) begin
        int k = (off - 19) / 20;
        int e = expect_meas(ma, mb);
        chk(meas_valid, "R7 valid at offset", meas_valid, 1);
        chk(meas == 10'(e), "R4 R5 R3 measurement value", meas, e);
        chk(frame_start == (k == 0), "R7 frame_start", frame_start, k == 0);
        model_step();  // R6
      end else begin
        if (meas_valid || frame_start || sample_req) stray++;
      end
    end
    chk(stray == 0, "R8 R2 no stray pulses", stray, 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk(meas == 0, "R1 meas reset", meas, 0);
    chk(!meas_valid, "R1 meas_valid reset", meas_valid, 0);
    chk(!frame_start, "R1 frame_start reset", frame_start, 0);
    chk(!sample_req, "R1 sample_req reset", sample_req, 0);
    rst = 1'b0;
    ma = 7'h55;
    mb = 9'h1A5;
    @(negedge clk);
    chk(!meas_valid && !sample_req, "R1 quiet after reset", meas_valid, 0);
  endtask

  task automatic t_basic();
    m_cfg = 5'd4;
    for (int i = 0; i < NCH; i++) vals[i] = 8'(i * 13 + 7);
    enable = 1'b1;
    do_frame(4);
    for (int i = 0; i < NCH; i++) vals[i] = (i % 2 == 0) ? 8'hF0 : 8'h0F;
    do_frame(4);
  endtask

  task automatic t_max();
    m_cfg = 5'd1;
    for (int i = 0; i < NCH; i++) vals[i] = 8'hFF;
    do_frame(1);
    do_frame(1);
    for (int i = 0; i < NCH; i++) vals[i] = 8'h00;
    do_frame(1);
  endtask

  task automatic t_clamp();
    m_cfg = 5'd9;
    for (int i = 0; i < NCH; i++) vals[i] = 8'(200 - i * 11);
    do_frame(5);
    m_cfg = 5'd0;
    do_frame(1);
    m_cfg = 5'd5;
    do_frame(5);
  endtask

  task automatic t_disable();
    int stray = 0;
    enable = 1'b0;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      if (meas_valid || sample_req || frame_start) stray++;
    end
    chk(stray == 0, "R2 idle while disabled", stray, 0);
    m_cfg = 5'd3;
    for (int i = 0; i < NCH; i++) vals[i] = 8'(i * 29 + 3);
    enable = 1'b1;
    do_frame(3);
  endtask

  initial begin
    #(20 * 150000);
    checks++;
    fails++;
    $display("FAIL R2 watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_max();
    t_clamp();
    t_disable();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule